// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block decides which one of eight interrupt request lines should be presented to the processor. It takes three 8-bit vectors: the latched requests, the mask and the in-service set. It also takes a rotation base and three mode pins: special masking, special nesting and a master strap. Priority is measured relative to the rotation base. The line sitting at the base is the most urgent. Urgency falls as the line number climbs from the base and wraps past 7 back to 0.

The block finds the most urgent unmasked request and the most urgent level still in service. It raises the interrupt only when the request strictly outranks that level. The mode pins take certain in-service bits out of that comparison. All outputs are registered, so the result reflects the inputs sampled at the previous rising clock edge. Latching the requests, acknowledging them, the end-of-service logic and any register access all live outside this block.

All pins are plain level signals with no handshake. The block never applies back-pressure. A new set of inputs may be presented on every cycle, and each set is resolved one cycle later.

Top module: `irq_rank_resolver`

## Requirements
- R1: A line's rank is its distance above the rotation base: rank r belongs to line (r + offset_i) mod 8. Rank 0 is the most urgent.
- R2: The candidate requests are req_i with every bit cleared where mask_i is 1. When no candidate remains, valid_o stays 0 whatever isr_i holds.
- R3: The current level is the lowest rank among the considered in-service bits. With no considered in-service bit, any candidate request wins.
- R4: When smm_i is 1, in-service bits whose mask_i bit is 1 are left out of the current level. When smm_i is 0, every in-service bit counts.
- R5: When master_i and sfnm_i are both 1, in-service bit 2 is left out of the current level. If either pin is 0, that bit counts.
- R6: A request wins only if its rank is strictly lower than the current level. A request at the same rank as the current level is blocked.
- R7: When a request wins, line_o carries the line number of the lowest-ranked candidate, which is (rank + offset_i) mod 8.
- R8: valid_o and int_o are equal at all times. Both update at the rising edge after the inputs change. Both are 0 while rst_ni is low.
- R9: line_o reads 0 whenever valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 8 | Latched request vector, bit n = line n |
| mask_i | input | 8 | Mask vector, 1 = line masked |
| isr_i | input | 8 | In-service vector, bit n = line n |
| offset_i | input | 3 | Rotation base: the line holding rank 0 |
| smm_i | input | 1 | Special masking: masked in-service bits do not block |
| sfnm_i | input | 1 | Special nesting: cascade in-service bit ignored on the master |
| master_i | input | 1 | Strap, 1 = this resolver is the master |
| valid_o | output | 1 | A request outranks the current level |
| line_o | output | 3 | Winning line number, 0 when none |
| int_o | output | 1 | Interrupt output to the processor |

## Verification
Every output is due exactly one rising edge after its inputs. The bench drives inputs on the falling edge and checks valid_o, line_o and int_o on the next falling edge, just after the register has loaded. One scenario also samples one nanosecond after a change, before any rising edge has passed, and expects the old result to still be held. The directed cases and a run of random vectors are all scored against a behavioural rank model written in the bench.

// File: rtl/irq_rank_pkg.sv
package irq_rank_pkg;
  localparam int unsigned DEF_LINES   = 8;
  localparam int unsigned DEF_CASCADE = 2;

  typedef struct packed {
    logic smm;
    logic sfnm;
    logic is_master;
  } irq_mode_t;
endpackage

// File: rtl/irq_rank_finder.sv
// Rotated priority encoder: returns the rank of the first set bit
// counted upward from the base, or LINES when the vector is empty.
module irq_rank_finder #(
  parameter int unsigned LINES = 8,
  localparam int unsigned IDW  = $clog2(LINES),
  localparam int unsigned RW   = $clog2(LINES + 1)
) (
  input  logic [LINES-1:0] vec_i,
  input  logic [IDW-1:0]   base_i,
  output logic [RW-1:0]    rank_o
);
  logic [2*LINES-1:0] doubled;
  logic [LINES-1:0]   rotated;

  always_comb begin
    doubled = {vec_i, vec_i} >> base_i;
    rotated = doubled[LINES-1:0];
  end

  always_comb begin
    rank_o = RW'(LINES);
    for (int r = LINES - 1; r >= 0; r--) begin
      if (rotated[r]) rank_o = RW'(r);
    end
  end
endmodule

// File: rtl/irq_level_filter.sv
// Selects which in-service bits take part in the current-level search.
module irq_level_filter
  import irq_rank_pkg::*;
#(
  parameter int unsigned LINES   = 8,
  parameter int unsigned CASCADE = 2
) (
  input  logic [LINES-1:0] isr_i,
  input  logic [LINES-1:0] mask_i,
  input  irq_mode_t        mode_i,
  output logic [LINES-1:0] level_o
);
  logic drop_cascade;
  assign drop_cascade = mode_i.is_master & mode_i.sfnm;

  for (genvar g = 0; g < LINES; g++) begin : g_bit
    if (g == CASCADE) begin : g_casc
      assign level_o[g] = isr_i[g] & ~(mode_i.smm & mask_i[g]) & ~drop_cascade;
    end else begin : g_plain
      assign level_o[g] = isr_i[g] & ~(mode_i.smm & mask_i[g]);
    end
  end
endmodule

// File: rtl/irq_rank_resolver.sv
module irq_rank_resolver
  import irq_rank_pkg::*;
#(
  parameter int unsigned LINES   = DEF_LINES,
  parameter int unsigned CASCADE = DEF_CASCADE,
  localparam int unsigned IDW    = $clog2(LINES),
  localparam int unsigned RW     = $clog2(LINES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] req_i,
  input  logic [LINES-1:0] mask_i,
  input  logic [LINES-1:0] isr_i,
  input  logic [IDW-1:0]   offset_i,
  input  logic             smm_i,
  input  logic             sfnm_i,
  input  logic             master_i,
  output logic             valid_o,
  output logic [IDW-1:0]   line_o,
  output logic             int_o
);
  irq_mode_t        mode;
  logic [LINES-1:0] pending;
  logic [LINES-1:0] level_bits;
  logic [RW-1:0]    pend_rank;
  logic [RW-1:0]    cur_rank;
  logic [RW-1:0]    line_sum;
  logic             win;
  logic [IDW-1:0]   win_line;

  assign mode    = '{smm: smm_i, sfnm: sfnm_i, is_master: master_i};
  assign pending = req_i & ~mask_i;

  irq_level_filter #(.LINES(LINES), .CASCADE(CASCADE)) u_filter (
    .isr_i  (isr_i),
    .mask_i (mask_i),
    .mode_i (mode),
    .level_o(level_bits)
  );

  irq_rank_finder #(.LINES(LINES)) u_pend_rank (
    .vec_i (pending),
    .base_i(offset_i),
    .rank_o(pend_rank)
  );

  irq_rank_finder #(.LINES(LINES)) u_cur_rank (
    .vec_i (level_bits),
    .base_i(offset_i),
    .rank_o(cur_rank)
  );

  always_comb begin
    win      = pend_rank < cur_rank;
    line_sum = pend_rank + RW'(offset_i);
    win_line = win ? line_sum[IDW-1:0] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      line_o  <= '0;
      int_o   <= 1'b0;
    end else begin
      valid_o <= win;
      line_o  <= win_line;
      int_o   <= win;
    end
  end
endmodule

// File: rtl/irq_rank_resolver_chk.sv
module irq_rank_resolver_chk #(
  parameter int unsigned LINES   = 8,
  parameter int unsigned CASCADE = 2,
  localparam int unsigned IDW    = $clog2(LINES)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [LINES-1:0] req_i,
  input logic [LINES-1:0] mask_i,
  input logic [LINES-1:0] isr_i,
  input logic [IDW-1:0]   offset_i,
  input logic             smm_i,
  input logic             sfnm_i,
  input logic             master_i,
  input logic             valid_o,
  input logic [IDW-1:0]   line_o,
  input logic             int_o
);
  logic [LINES-1:0] cand;
  logic             cascade_hidden;
  assign cand           = req_i & ~mask_i;
  assign cascade_hidden = master_i & sfnm_i & (32'(offset_i) == CASCADE);

  AST_INT_TRACKS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o == valid_o); // R8
  AST_IDLE_LINE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> line_o == '0); // R9
  AST_NO_CAND_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cand == '0 |=> !valid_o); // R2
  AST_WINNER_IS_CAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (($past(req_i) & ~$past(mask_i)) & (LINES'(1) << line_o)) != '0); // R7
  AST_EMPTY_LEVEL_ANY_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (isr_i == '0 && cand != '0) |=> valid_o); // R3
  AST_BASE_LINE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cand[offset_i] && !isr_i[offset_i]) |=> (valid_o && line_o == $past(offset_i))); // R1
  AST_SAME_RANK_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!smm_i && isr_i[offset_i] && !cascade_hidden) |=> !valid_o); // R6
endmodule

bind irq_rank_resolver irq_rank_resolver_chk #(.LINES(LINES), .CASCADE(CASCADE)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .mask_i  (mask_i),
  .isr_i   (isr_i),
  .offset_i(offset_i),
  .smm_i   (smm_i),
  .sfnm_i  (sfnm_i),
  .master_i(master_i),
  .valid_o (valid_o),
  .line_o  (line_o),
  .int_o   (int_o)
);

// File: tb/irq_rank_resolver_tb_top.sv
`timescale 1ns/1ps
module irq_rank_resolver_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req = '0, mask = '0, isr = '0;
  logic [2:0] off = '0;
  logic       smm = 1'b0, sfnm = 1'b0, mst = 1'b0;
  logic       valid, intr;
  logic [2:0] line;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  irq_rank_resolver dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .mask_i(mask), .isr_i(isr),
    .offset_i(off), .smm_i(smm), .sfnm_i(sfnm), .master_i(mst),
    .valid_o(valid), .line_o(line), .int_o(intr)
  );

  function automatic logic [3:0] model(input logic [7:0] rq, mk, is,
                                       input logic [2:0] base,
                                       input logic sm, sf, ms);
    int pr = 8;
    int cr = 8;
    logic [7:0] pend = rq & ~mk;
    logic [7:0] lev = is;
    if (sm) lev = lev & ~mk;
    if (ms && sf) lev[2] = 1'b0;
    for (int r = 7; r >= 0; r--) begin
      if (pend[(r + int'(base)) % 8]) pr = r;
      if (lev[(r + int'(base)) % 8]) cr = r;
    end
    if (pr < cr) return {1'b1, 3'((pr + int'(base)) % 8)};
    return 4'b0;
  endfunction

  task automatic check(input string tag, input logic ev, input logic [2:0] el);
    checks++;
    if (valid !== ev || intr !== ev || line !== el) begin
      errors++;
      $display("FAIL %s: valid=%0b int=%0b line=%0d expected valid=%0b int=%0b line=%0d",
               tag, valid, intr, line, ev, ev, el);
    end
  endtask

  task automatic apply(input logic [7:0] rq, mk, is, input logic [2:0] base,
                       input logic sm, sf, ms);
    @(negedge clk);
    req = rq; mask = mk; isr = is; off = base; smm = sm; sfnm = sf; mst = ms;
    @(negedge clk);
  endtask

  task automatic t_reset;
    req = 8'hFF;
    repeat (3) @(negedge clk);
    check("R8 reset", 1'b0, 3'd0);
    rst_n = 1'b1;
    apply(8'h00, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0);
    check("R9 idle after reset", 1'b0, 3'd0);
  endtask

  task automatic t_rotation;
    apply(8'h05, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0);
    check("R1 base 0", 1'b1, 3'd0);
    apply(8'h05, 8'h00, 8'h00, 3'd1, 1'b0, 1'b0, 1'b0);
    check("R1 base 1", 1'b1, 3'd2);
    apply(8'h05, 8'h00, 8'h00, 3'd3, 1'b0, 1'b0, 1'b0);
    check("R7 wrap base 3", 1'b1, 3'd0);
    apply(8'h01, 8'h00, 8'h00, 3'd7, 1'b0, 1'b0, 1'b0);
    check("R7 wrap base 7", 1'b1, 3'd0);
  endtask

  task automatic t_masking;
    apply(8'hFF, 8'hFF, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0);
    check("R2 all masked", 1'b0, 3'd0);
    apply(8'h10, 8'hEF, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0);
    check("R2 one unmasked", 1'b1, 3'd4);
  endtask

  task automatic t_nesting;
    apply(8'h10, 8'h00, 8'h08, 3'd0, 1'b0, 1'b0, 1'b0);
    check("R3 lower urgency blocked", 1'b0, 3'd0);
    apply(8'h08, 8'h00, 8'h08, 3'd0, 1'b0, 1'b0, 1'b0);
    check("R6 equal rank blocked", 1'b0, 3'd0);
    apply(8'h04, 8'h00, 8'h08, 3'd0, 1'b0, 1'b0, 1'b0);
    check("R3 higher urgency wins", 1'b1, 3'd2);
  endtask

  task automatic t_special_mask;
    apply(8'h20, 8'h02, 8'h02, 3'd0, 1'b1, 1'b0, 1'b0);
    check("R4 masked level ignored", 1'b1, 3'd5);
    apply(8'h20, 8'h02, 8'h02, 3'd0, 1'b0, 1'b0, 1'b0);
    check("R4 mode off blocks", 1'b0, 3'd0);
  endtask

  task automatic t_cascade;
    apply(8'h04, 8'h00, 8'h04, 3'd0, 1'b0, 1'b1, 1'b1);
    check("R5 cascade ignored on master", 1'b1, 3'd2);
    apply(8'h40, 8'h00, 8'h04, 3'd0, 1'b0, 1'b1, 1'b1);
    check("R5 lower line passes cascade", 1'b1, 3'd6);
    apply(8'h04, 8'h00, 8'h04, 3'd0, 1'b0, 1'b1, 1'b0);
    check("R5 slave keeps cascade bit", 1'b0, 3'd0);
    apply(8'h04, 8'h00, 8'h04, 3'd0, 1'b0, 1'b0, 1'b1);
    check("R5 nesting off keeps bit", 1'b0, 3'd0);
  endtask

  task automatic t_latency;
    apply(8'h80, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0);
    check("R8 settled", 1'b1, 3'd7);
    @(negedge clk);
    req = 8'h00;
    #1;
    check("R8 held before edge", 1'b1, 3'd7);
    @(negedge clk);
    check("R8 cleared after edge", 1'b0, 3'd0);
  endtask

  task automatic t_random;
    for (int i = 0; i < 300; i++) begin
      logic [3:0] e;
      logic [7:0] rq = 8'($urandom), mk = 8'($urandom & $urandom), is = 8'($urandom & $urandom);
      logic [2:0] b = 3'($urandom);
      logic sm = 1'($urandom), sf = 1'($urandom), ms = 1'($urandom);
      apply(rq, mk, is, b, sm, sf, ms);
      e = model(rq, mk, is, b, sm, sf, ms);
      check("R1 R3 R7 random vs model", e[3], e[2:0]);
    end
  endtask

  initial begin
    t_reset();
    t_rotation();
    t_masking();
    t_nesting();
    t_special_mask();
    t_cascade();
    t_latency();
    t_random();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule